// File: doc/BRIEF.md
# Floating-point opcode decoder with stack-top tracking

The block receives the first two opcode bytes of a floating-point instruction together with a valid strobe. It checks that the first byte carries the floating-point escape pattern 11011 in its upper five bits. It then sorts the instruction into memory form or register form and extracts the fields that later stages need: the memory operand format, the addressing fields, the operation class, the destination selection and the operand order.

A circular 3-bit pointer tracks the top of an eight-entry register stack. Pushes, pops and the explicit pointer increment and decrement instructions all move this pointer. Relative stack indices are turned into physical register numbers through the pointer value that was current before the instruction. Every decode output is registered, so the results appear one cycle after the strobe. Address generation, operand fetch and the arithmetic itself belong to other blocks.

Top module: `fp_stack_decoder`

## Requirements
- R1: When a strobed byte0_i has bits [7:3] different from 11011, the next cycle shows illegal_o=1 and all other decode outputs at 0, and top_o keeps its value.
- R2: A legal instruction is in register form when byte1_i[7:6]=11 (mem_form_o=0) and in memory form otherwise (mem_form_o=1). In memory form, mod_o=byte1_i[7:6] and rm_o=byte1_i[2:0]; in register form both are 0. op_class_o=byte1_i[5:3] for every legal instruction.
- R3: In memory form, mem_fmt_o=byte0_i[2:1], coded as 00 = 32-bit real, 01 = 32-bit integer, 10 = 64-bit real and 11 = 16-bit integer. In register form it is 0.
- R4: In register form, dest_sel_o=byte0_i[2]. When it is 0, dest_phys_o equals the pre-instruction top; when it is 1, dest_phys_o equals sti_phys_o. In memory form both dest_sel_o and dest_phys_o read as the top value (dest_sel_o=0).
- R5: In register form, swap_o=byte1_i[3] XOR byte0_i[2]: 0 means destination OP source and 1 means source OP destination. In memory form swap_o=0.
- R6: A register-form instruction with byte0_i[1]=1 that is not covered by R9 reports stack_adj_o=10 (pop once) and advances top_o by 1 modulo 8.
- R7: sti_phys_o=(T + byte1_i[2:0]) mod 8, where T is top_o before the instruction; field value 0 names the stack top.
- R8: Byte pair D9 F7 gives ptr_only_o=1, stack_adj_o=10 and top +1. Byte pair D9 F6 gives ptr_only_o=1, stack_adj_o=01 and top -1. ptr_only_o is 0 for every other instruction.
- R9: Byte pair DE D9 reports stack_adj_o=11 (pop twice) and advances top_o by 2 modulo 8.
- R10: The push forms report stack_adj_o=01 and move top_o back by 1 modulo 8. These are the memory forms with (byte0_i[2:0], byte1_i[5:3]) equal to (001,000), (101,000), (011,000), (011,101), (111,000), (111,100) or (111,101), and the register form D9 C0..C7. All other legal instructions report 00 and leave top_o unchanged.
- R11: valid_o is high for exactly the one cycle after each strobe. The decode outputs and the top pointer update on that same edge. Reset clears top_o and valid_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe for the opcode bytes |
| byte0_i | input | 8 | First opcode byte |
| byte1_i | input | 8 | Second opcode byte |
| valid_o | output | 1 | Decode result valid (one cycle) |
| illegal_o | output | 1 | Wrong escape pattern |
| mem_form_o | output | 1 | Memory form when 1 |
| mem_fmt_o | output | 2 | Memory operand format |
| mod_o | output | 2 | Addressing mode field for the address unit |
| rm_o | output | 3 | Register/memory field for the address unit |
| op_class_o | output | 3 | Operation class |
| dest_sel_o | output | 1 | 0: result to stack top, 1: result to ST(i) |
| swap_o | output | 1 | Source OP destination when 1 |
| stack_adj_o | output | 2 | 00 none, 01 push, 10 pop once, 11 pop twice |
| ptr_only_o | output | 1 | Pointer move with no data operation |
| sti_phys_o | output | 3 | Physical register of ST(i) |
| dest_phys_o | output | 3 | Physical register of the destination |
| top_o | output | 3 | Current stack-top pointer |

## Verification
Every one of the 2048 byte pairs that carry the legal escape is applied in sequence. The stack pointer therefore drifts through all eight values, and each index mapping is tried against many different top values and wrap-around points. This sweep tells memory form from register form on every value of byte1_i[7:6]. It also separates each special byte pair from its neighbours, which differ only in the P, d or R bit. A second sweep uses wrong escape prefixes with assorted second bytes to show that they change nothing, and an idle cycle after a pointer move shows that the pointer holds.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam logic [4:0] ESC_PREFIX = 5'b11011;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'b00,
    ADJ_PUSH = 2'b01,
    ADJ_POP1 = 2'b10,
    ADJ_POP2 = 2'b11
  } stk_adj_e;

  typedef struct packed {
    logic       illegal;
    logic       mem_form;
    logic [1:0] mem_fmt;
    logic [1:0] mod;
    logic [2:0] rm;
    logic [2:0] op_class;
    logic       dest_sel;
    logic       swap;
    logic       ptr_only;
    stk_adj_e   adj;
    logic [2:0] rel_idx;
  } dec_t;
endpackage

// File: rtl/fpd_field_decode.sv
module fpd_field_decode
  import fpd_pkg::*;
(
  input  logic [7:0] byte0_i,
  input  logic [7:0] byte1_i,
  output dec_t       dec_o
);
  logic       reg_form;
  logic [2:0] grp;
  logic [2:0] sub;
  logic       mem_load;

  assign reg_form = (byte1_i[7:6] == 2'b11);
  assign grp      = byte0_i[2:0];
  assign sub      = byte1_i[5:3];

  always_comb begin
    unique case (grp)
      3'b001, 3'b101: mem_load = (sub == 3'd0);
      3'b011:         mem_load = (sub == 3'd0) || (sub == 3'd5);
      3'b111:         mem_load = (sub == 3'd0) || (sub == 3'd4) || (sub == 3'd5);
      default:        mem_load = 1'b0;
    endcase
  end

  always_comb begin
    dec_o     = '0;
    dec_o.adj = ADJ_NONE;
    if (byte0_i[7:3] != ESC_PREFIX) begin
      dec_o.illegal = 1'b1;
    end else begin
      dec_o.op_class = sub;
      dec_o.mem_form = !reg_form;
      dec_o.rel_idx  = byte1_i[2:0];
      if (!reg_form) begin
        dec_o.mem_fmt = byte0_i[2:1];
        dec_o.mod     = byte1_i[7:6];
        dec_o.rm      = byte1_i[2:0];
        if (mem_load) dec_o.adj = ADJ_PUSH;
      end else begin
        dec_o.dest_sel = byte0_i[2];
        dec_o.swap     = byte1_i[3] ^ byte0_i[2];
        // special pairs take priority over the P bit
        if (grp == 3'b001 && byte1_i == 8'hF7) begin
          dec_o.ptr_only = 1'b1;
          dec_o.adj      = ADJ_POP1;
        end else if (grp == 3'b001 && byte1_i == 8'hF6) begin
          dec_o.ptr_only = 1'b1;
          dec_o.adj      = ADJ_PUSH;
        end else if (grp == 3'b110 && byte1_i == 8'hD9) begin
          dec_o.adj = ADJ_POP2;
        end else if (grp == 3'b001 && byte1_i[7:3] == 5'b11000) begin
          dec_o.adj = ADJ_PUSH;
        end else if (byte0_i[1]) begin
          dec_o.adj = ADJ_POP1;
        end
      end
    end
  end
endmodule

// File: rtl/fpd_top_ptr.sv
module fpd_top_ptr
  import fpd_pkg::*;
#(
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  stk_adj_e         adj_i,
  output logic [PTR_W-1:0] top_o
);
  logic [PTR_W-1:0] top_d;

  always_comb begin
    unique case (adj_i)
      ADJ_PUSH: top_d = top_o - PTR_W'(1);
      ADJ_POP1: top_d = top_o + PTR_W'(1);
      ADJ_POP2: top_d = top_o + PTR_W'(2);
      default:  top_d = top_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   top_o <= '0;
    else if (en_i) top_o <= top_d;
  end
endmodule

// File: rtl/fpd_idx_map.sv
module fpd_idx_map #(
  parameter int unsigned PTR_W = 3
) (
  input  logic [PTR_W-1:0] top_i,
  input  logic [PTR_W-1:0] rel_i,
  input  logic             dest_sel_i,
  output logic [PTR_W-1:0] sti_phys_o,
  output logic [PTR_W-1:0] dest_phys_o
);
  assign sti_phys_o  = top_i + rel_i;  // wraps modulo depth
  assign dest_phys_o = dest_sel_i ? sti_phys_o : top_i;
endmodule

// File: rtl/fp_stack_decoder.sv
module fp_stack_decoder
  import fpd_pkg::*;
#(
  parameter int unsigned STK_DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] byte0_i,
  input  logic [7:0] byte1_i,
  output logic       valid_o,
  output logic       illegal_o,
  output logic       mem_form_o,
  output logic [1:0] mem_fmt_o,
  output logic [1:0] mod_o,
  output logic [2:0] rm_o,
  output logic [2:0] op_class_o,
  output logic       dest_sel_o,
  output logic       swap_o,
  output logic [1:0] stack_adj_o,
  output logic       ptr_only_o,
  output logic [2:0] sti_phys_o,
  output logic [2:0] dest_phys_o,
  output logic [2:0] top_o
);
  localparam int unsigned PTR_W = $clog2(STK_DEPTH);

  dec_t             dec;
  dec_t             dec_q;
  logic [PTR_W-1:0] top;
  logic [PTR_W-1:0] sti_phys, dest_phys;
  logic [PTR_W-1:0] sti_q, dest_q;
  logic             valid_q;

  fpd_field_decode u_dec (
    .byte0_i (byte0_i),
    .byte1_i (byte1_i),
    .dec_o   (dec)
  );

  fpd_idx_map #(.PTR_W(PTR_W)) u_map (
    .top_i       (top),
    .rel_i       (dec.rel_idx[PTR_W-1:0]),
    .dest_sel_i  (dec.dest_sel),
    .sti_phys_o  (sti_phys),
    .dest_phys_o (dest_phys)
  );

  fpd_top_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i && !dec.illegal),
    .adj_i  (dec.adj),
    .top_o  (top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dec_q   <= '0;
      sti_q   <= '0;
      dest_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        dec_q  <= dec;
        sti_q  <= dec.illegal ? '0 : sti_phys;
        dest_q <= dec.illegal ? '0 : dest_phys;
      end
    end
  end

  assign valid_o     = valid_q;
  assign illegal_o   = dec_q.illegal;
  assign mem_form_o  = dec_q.mem_form;
  assign mem_fmt_o   = dec_q.mem_fmt;
  assign mod_o       = dec_q.mod;
  assign rm_o        = dec_q.rm;
  assign op_class_o  = dec_q.op_class;
  assign dest_sel_o  = dec_q.dest_sel;
  assign swap_o      = dec_q.swap;
  assign stack_adj_o = dec_q.adj;
  assign ptr_only_o  = dec_q.ptr_only;
  assign sti_phys_o  = 3'(sti_q);
  assign dest_phys_o = 3'(dest_q);
  assign top_o       = 3'(top);
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_o,
  input logic       illegal_o,
  input logic       mem_form_o,
  input logic [1:0] mem_fmt_o,
  input logic       swap_o,
  input logic [1:0] stack_adj_o,
  input logic       ptr_only_o,
  input logic [2:0] top_o
);
  AST_ILLEGAL_HOLDS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> top_o == $past(top_o)) else $error("illegal moved top"); // R1

  AST_IDLE_HOLDS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> top_o == $past(top_o)) else $error("top moved while idle"); // R11

  AST_PUSH_MOVES_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !illegal_o && stack_adj_o == 2'b01 |-> top_o == 3'($past(top_o) - 3'd1))
    else $error("push step"); // R10

  AST_POP1_MOVES_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !illegal_o && stack_adj_o == 2'b10 |-> top_o == 3'($past(top_o) + 3'd1))
    else $error("pop step"); // R6

  AST_POP2_MOVES_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !illegal_o && stack_adj_o == 2'b11 |-> top_o == 3'($past(top_o) + 3'd2))
    else $error("double pop step"); // R9

  AST_MEM_NO_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && mem_form_o |-> !swap_o) else $error("swap in memory form"); // R5

  AST_REG_NO_FMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !mem_form_o |-> mem_fmt_o == 2'b00) else $error("format in register form"); // R3

  AST_PTR_ONLY_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ptr_only_o |-> !mem_form_o && stack_adj_o inside {2'b01, 2'b10})
    else $error("pointer-only shape"); // R8
endmodule

bind fp_stack_decoder fpd_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_o     (valid_o),
  .illegal_o   (illegal_o),
  .mem_form_o  (mem_form_o),
  .mem_fmt_o   (mem_fmt_o),
  .swap_o      (swap_o),
  .stack_adj_o (stack_adj_o),
  .ptr_only_o  (ptr_only_o),
  .top_o       (top_o)
);

// File: tb/fp_stack_decoder_tb.sv
module fp_stack_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] b0 = '0, b1 = '0;
  logic       valid_o, illegal_o, mem_form_o, dest_sel_o, swap_o, ptr_only_o;
  logic [1:0] mem_fmt_o, mod_o, stack_adj_o;
  logic [2:0] rm_o, op_class_o, sti_phys_o, dest_phys_o, top_o;

  int checks = 0;
  int errors = 0;
  int exp_top = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  fp_stack_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .byte0_i(b0), .byte1_i(b1),
    .valid_o(valid_o), .illegal_o(illegal_o), .mem_form_o(mem_form_o),
    .mem_fmt_o(mem_fmt_o), .mod_o(mod_o), .rm_o(rm_o), .op_class_o(op_class_o),
    .dest_sel_o(dest_sel_o), .swap_o(swap_o), .stack_adj_o(stack_adj_o),
    .ptr_only_o(ptr_only_o), .sti_phys_o(sti_phys_o), .dest_phys_o(dest_phys_o),
    .top_o(top_o)
  );

  task automatic chk(string req, int act, int exp, logic [7:0] x0, logic [7:0] x1);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s bytes %h %h: actual=%0d expected=%0d", req, x0, x1, act, exp);
    end
  endtask

  task automatic send(logic [7:0] x0, logic [7:0] x1);
    int t0, adj, sti, dsel, regf, grp, sub;
    bit load;
    @(negedge clk);
    b0 = x0; b1 = x1; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    t0 = exp_top;
    chk("R11 valid", int'(valid_o), 1, x0, x1);
    if (x0[7:3] != 5'b11011) begin
      chk("R1 illegal", int'(illegal_o), 1, x0, x1);
      chk("R1 zeros", int'({mem_form_o, mem_fmt_o, mod_o, rm_o, op_class_o, dest_sel_o,
                            swap_o, stack_adj_o, ptr_only_o, sti_phys_o, dest_phys_o}), 0, x0, x1);
      chk("R1 top", int'(top_o), exp_top, x0, x1);
      return;
    end
    chk("R1 legal", int'(illegal_o), 0, x0, x1);
    regf = (x1[7:6] == 2'b11) ? 1 : 0;
    grp  = int'(x0[2:0]);
    sub  = int'(x1[5:3]);
    chk("R2 form", int'(mem_form_o), 1 - regf, x0, x1);
    chk("R2 op_class", int'(op_class_o), sub, x0, x1);
    chk("R2 mod", int'(mod_o), regf ? 0 : int'(x1[7:6]), x0, x1);
    chk("R2 rm", int'(rm_o), regf ? 0 : int'(x1[2:0]), x0, x1);
    chk("R3 fmt", int'(mem_fmt_o), regf ? 0 : int'(x0[2:1]), x0, x1);
    dsel = regf ? int'(x0[2]) : 0;
    chk("R4 dest_sel", int'(dest_sel_o), dsel, x0, x1);
    chk("R5 swap", int'(swap_o), regf ? int'(x1[3] ^ x0[2]) : 0, x0, x1);
    sti = (t0 + int'(x1[2:0])) % 8;
    chk("R7 sti_phys", int'(sti_phys_o), sti, x0, x1);
    chk("R4 dest_phys", int'(dest_phys_o), dsel ? sti : t0, x0, x1);
    adj = 0;
    if (!regf) begin
      load = (grp == 1 && sub == 0) || (grp == 5 && sub == 0) ||
             (grp == 3 && (sub == 0 || sub == 5)) ||
             (grp == 7 && (sub == 0 || sub == 4 || sub == 5));
      if (load) adj = 1;
      chk("R10 mem adj", int'(stack_adj_o), adj, x0, x1);
      chk("R8 no ptr_only", int'(ptr_only_o), 0, x0, x1);
    end else if (grp == 1 && x1 == 8'hF7) begin
      adj = 2;
      chk("R8 inc adj", int'(stack_adj_o), adj, x0, x1);
      chk("R8 inc flag", int'(ptr_only_o), 1, x0, x1);
    end else if (grp == 1 && x1 == 8'hF6) begin
      adj = 1;
      chk("R8 dec adj", int'(stack_adj_o), adj, x0, x1);
      chk("R8 dec flag", int'(ptr_only_o), 1, x0, x1);
    end else if (grp == 6 && x1 == 8'hD9) begin
      adj = 3;
      chk("R9 pop2", int'(stack_adj_o), adj, x0, x1);
      chk("R8 no ptr_only", int'(ptr_only_o), 0, x0, x1);
    end else if (grp == 1 && x1[7:3] == 5'b11000) begin
      adj = 1;
      chk("R10 reg load", int'(stack_adj_o), adj, x0, x1);
      chk("R8 no ptr_only", int'(ptr_only_o), 0, x0, x1);
    end else begin
      adj = x0[1] ? 2 : 0;
      chk("R6 p bit", int'(stack_adj_o), adj, x0, x1);
      chk("R8 no ptr_only", int'(ptr_only_o), 0, x0, x1);
    end
    case (adj)
      1: exp_top = (t0 + 7) % 8;
      2: exp_top = (t0 + 1) % 8;
      3: exp_top = (t0 + 2) % 8;
      default: exp_top = t0;
    endcase
    chk((adj == 3) ? "R9 top" : (adj == 2) ? "R6 top" : "R10 top", int'(top_o), exp_top, x0, x1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset valid", int'(valid_o), 0, 8'h0, 8'h0);
    chk("R11 reset top", int'(top_o), 0, 8'h0, 8'h0);
    rst_n = 1'b1;
    // targeted corners first
    send(8'hD9, 8'hF6);  // dec: top 0 -> 7
    send(8'hD9, 8'hF7);  // inc: back to 0
    send(8'hDE, 8'hD9);  // pop twice: 2
    @(negedge clk);
    chk("R11 idle valid", int'(valid_o), 0, 8'h0, 8'h0);
    chk("R11 idle top", int'(top_o), exp_top, 8'h0, 8'h0);
    // full sweep over legal byte pairs
    for (int g = 0; g < 8; g++)
      for (int s = 0; s < 256; s++)
        send({5'b11011, 3'(g)}, 8'(s));
    // wrong prefixes
    for (int p = 0; p < 32; p++)
      if (p != 27)
        for (int s = 0; s < 256; s += 37)
          send({5'(p), 3'(s % 8)}, 8'(s));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule